// File: doc/BRIEF.md
# Prescaled 24-bit Programmable Timer

A down-counting timer built around a 24-bit counter. The counter can be stepped by every system clock cycle, by every rising edge of an external clock input, or by either of those divided by 32 through a 5-bit prescaler. When the count passes through zero, the timer either reloads from a 24-bit preload register or, in single-shot mode, wraps to all ones and keeps running. A zero crossing sets a sticky status flag, and that flag can drive an interrupt request.

Software programs the timer through a byte-wide register bus. It can use the timer in three ways. Periodic mode gives a regular interrupt. Square-wave mode toggles the timer output pin on every zero crossing. Single-shot mode gives one interrupt after a programmed delay. In single-shot mode, the live count can be read back to measure elapsed time. The external clock input is asynchronous. It passes through a two-stage synchronizer and a rising-edge detector before it can step the counter.

Top module: `ptimer24`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `tmr_out` are low.
- R2: Register map (address: contents):
  - 0: control. Bit 0 is run. Bits 2:1 are mode: 00 periodic, 01 square wave, 1x single shot. Bit 3 selects the external clock. Bit 4 enables the prescaler. Bit 5 enables the interrupt.
  - 1, 2, 3: preload bytes, least significant first.
  - 4, 5, 6: count bytes, least significant first. These are read-only.
  - 7: status. Bit 0 is the zero flag.

  Writes take effect at the clock edge. Reads are combinational from `addr`.
- R3: While run is 0, the count follows the preload register with one cycle of delay. The prescaler is held at zero and `tmr_out` is low.
- R4: While run is 1, each counter step lowers a nonzero count by exactly one. With the internal clock and no prescaler, the counter steps on every clock cycle.
- R5: With the prescaler enabled, the counter steps once for every 32 source events.
- R6: With the external clock selected, a source event is a synchronized rising edge of `ext_clk`. If `ext_clk` rises before clock edge k, the count changes at edge k+2. A level that is held high steps the counter only once.
- R7: In periodic mode, a step at count 0 reloads the preload value and sets the zero flag. The period is therefore preload+1 steps.
- R8: In square-wave mode, a step at count 0 reloads the preload value, sets the zero flag and toggles `tmr_out`.
- R9: In single-shot mode, the first step at count 0 sets the zero flag. That step and every later step at zero load 0xFFFFFF. Later zero crossings set no flag until run is cleared again.
- R10: The zero flag is sticky. Writing 1 to status bit 0 clears it. If a new zero crossing happens at the same edge as the clearing write, the flag stays set.
- R11: `irq` is high exactly when the zero flag is set and interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ext_clk | input | 1 | Asynchronous external count clock |
| tmr_out | output | 1 | Square-wave output |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases, each of which has a visible symptom when the design gets it wrong:
- A preload of small values exercises the zero crossing. A design that reloads one step early or late gives the wrong period and shows a misplaced flag.
- A flag-clearing write is made to coincide with a zero crossing. A design that lets the clear win loses an interrupt.
- Single-shot mode is run through its second zero crossing. A design that reloads, or that sets the flag again, shows up on the count bytes and on `irq`.
- The external clock is held high over many cycles and toggled with uneven spacing. A missing edge detector or a wrong synchronizer depth moves or repeats steps.
- The 32-event prescaler is run both from the internal clock and from the external clock.

// File: rtl/ptimer24.sv
module ptimer24 #(
  parameter int PRE_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ext_clk,
  output logic       tmr_out,
  output logic       irq
);
  localparam int CNT_W = 24;

  logic [5:0]       ctrl;
  logic [CNT_W-1:0] preload, cnt;
  logic [PRE_W-1:0] pre;
  logic             flag, done, tout;
  logic [2:0]       sync;

  wire run      = ctrl[0];
  wire [1:0] mode = ctrl[2:1];
  wire ext_sel  = ctrl[3];
  wire pre_en   = ctrl[4];
  wire irq_en   = ctrl[5];

  wire ext_rise = sync[1] & ~sync[2];
  wire src_evt  = ext_sel ? ext_rise : 1'b1;
  wire tick     = pre_en ? (src_evt && (&pre)) : src_evt;
  wire at_zero  = (cnt == '0);
  wire zero_evt = run && tick && at_zero && !(mode[1] && done);
  wire clr_req  = wr_en && addr == 3'd7 && wdata[0];

  assign irq     = flag & irq_en;
  assign tmr_out = tout;

  always_comb begin
    case (addr)
      3'd0: rdata = {2'b00, ctrl};
      3'd1: rdata = preload[7:0];
      3'd2: rdata = preload[15:8];
      3'd3: rdata = preload[23:16];
      3'd4: rdata = cnt[7:0];
      3'd5: rdata = cnt[15:8];
      3'd6: rdata = cnt[23:16];
      default: rdata = {7'd0, flag};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      preload <= '0;
      cnt     <= '0;
      pre     <= '0;
      flag    <= 1'b0;
      done    <= 1'b0;
      tout    <= 1'b0;
      sync    <= '0;
    end else begin
      sync <= {sync[1:0], ext_clk};

      if (wr_en) begin
        case (addr)
          3'd0: ctrl <= wdata[5:0];
          3'd1: preload[7:0]   <= wdata;
          3'd2: preload[15:8]  <= wdata;
          3'd3: preload[23:16] <= wdata;
          default: ;
        endcase
      end

      if (zero_evt)     flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;

      if (!run) begin
        cnt  <= preload;
        pre  <= '0;
        done <= 1'b0;
        tout <= 1'b0;
      end else begin
        if (src_evt && pre_en) pre <= pre + 1'b1;
        if (tick) begin
          if (!at_zero) begin
            cnt <= cnt - 1'b1;
          end else if (mode[1]) begin
            cnt  <= '1;
            done <= 1'b1;
          end else begin
            cnt <= preload;
            if (mode == 2'b01) tout <= ~tout;
          end
        end
      end
    end
  end
endmodule

module ptimer24_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  ctrl,
  input logic [23:0] preload,
  input logic [23:0] cnt,
  input logic        flag,
  input logic        tout,
  input logic        tick,
  input logic        ext_rise,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [7:0]  wdata
);
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |=> cnt == $past(preload)); // R3
  AST_TOUT_LOW_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |=> !tout); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && tick && cnt != 24'd0 |=> cnt == $past(cnt) - 24'd1); // R4
  AST_NO_EDGE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && ctrl[3] && !ctrl[4] && !ext_rise |=> cnt == $past(cnt)); // R6
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && ctrl[2:1] == 2'b00 && tick && cnt == 24'd0 |=> flag && cnt == $past(preload)); // R7
  AST_SQUARE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && ctrl[2:1] == 2'b01 && tick && cnt == 24'd0 |=> tout != $past(tout)); // R8
  AST_SINGLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && ctrl[2] && tick && cnt == 24'd0 |=> cnt == 24'hFFFFFF); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(wr_en && addr == 3'd7 && wdata[0]) |=> flag); // R10
endmodule

bind ptimer24 ptimer24_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .preload(preload), .cnt(cnt),
  .flag(flag), .tout(tout), .tick(tick), .ext_rise(ext_rise),
  .wr_en(wr_en), .addr(addr), .wdata(wdata)
);

// File: tb/ptimer24_tb.sv
module ptimer24_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic       ext_clk = 1'b0;
  logic [7:0] rdata;
  logic       tmr_out, irq;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  ptimer24 dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                  .rdata(rdata), .ext_clk(ext_clk), .tmr_out(tmr_out), .irq(irq));

  // behavioural reference
  logic [5:0]  m_ctrl;
  logic [23:0] m_pl, m_cnt;
  int          m_pre;
  bit          m_flag, m_done, m_tout;
  bit          hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_pl = 0; m_cnt = 0; m_pre = 0;
      m_flag = 0; m_done = 0; m_tout = 0;
      hist = '{0, 0, 0};
    end else begin
      bit rise, src, step, hit;
      rise = hist[1] && !hist[0];
      void'(hist.pop_front());
      hist.push_back(ext_clk);
      src  = m_ctrl[3] ? rise : 1'b1;
      step = m_ctrl[4] ? (src && m_pre == 31) : src;
      hit  = 0;
      if (!m_ctrl[0]) begin
        m_cnt = m_pl; m_pre = 0; m_done = 0; m_tout = 0;
      end else begin
        if (src && m_ctrl[4]) m_pre = (m_pre + 1) % 32;
        if (step) begin
          if (m_cnt != 0) m_cnt = m_cnt - 1;
          else if (m_ctrl[2]) begin
            if (!m_done) hit = 1;
            m_done = 1;
            m_cnt = 24'hFFFFFF;
          end else begin
            hit = 1;
            m_cnt = m_pl;
            if (m_ctrl[2:1] == 2'b01) m_tout = !m_tout;
          end
        end
      end
      if (hit) m_flag = 1;
      else if (wr_en && addr == 7 && wdata[0]) m_flag = 0;
      if (wr_en) begin
        case (addr)
          0: m_ctrl = wdata[5:0];
          1: m_pl[7:0] = wdata;
          2: m_pl[15:8] = wdata;
          3: m_pl[23:16] = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      0: return {2'b00, m_ctrl};
      1: return m_pl[7:0];
      2: return m_pl[15:8];
      3: return m_pl[23:16];
      4: return m_cnt[7:0];
      5: return m_cnt[15:8];
      6: return m_cnt[23:16];
      default: return {7'd0, m_flag};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(rdata == m_read(addr), cur_req, "rdata", rdata, m_read(addr));
    chk(irq == (m_flag && m_ctrl[5]), "R11", "irq", irq, m_flag && m_ctrl[5]);
    chk(tmr_out == m_tout, cur_req, "tmr_out", tmr_out, m_tout);
  end

  task automatic nxt(); @(posedge clk); #2; endtask
  task automatic run(input int n); repeat (n) nxt(); endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1; nxt(); wr_en = 1'b0;
  endtask
  task automatic set_pl(input logic [23:0] v);
    wr(1, v[7:0]); wr(2, v[15:8]); wr(3, v[23:16]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    nxt(); nxt();
    cur_req = "R1";
    chk(irq == 0 && tmr_out == 0 && rdata == 0, "R1", "reset outputs", {irq, tmr_out, rdata}, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin addr = a[2:0]; nxt(); end

    cur_req = "R2";
    set_pl(24'h563412);
    for (int a = 0; a < 8; a++) begin addr = a[2:0]; nxt(); end
    addr = 6; #1;
    chk(rdata == 8'h56, "R3", "stopped count high byte", rdata, 8'h56);

    cur_req = "R7";
    set_pl(24'd5);
    wr(0, 8'h21);
    addr = 4; run(14);
    addr = 7; run(3);
    cur_req = "R10";
    for (int i = 0; i < 12; i++) begin wr(7, 8'h01); run(2); end
    cur_req = "R4";
    addr = 4; run(8);

    cur_req = "R11";
    wr(0, 8'h00); wr(7, 8'h01);
    set_pl(24'd2);
    wr(0, 8'h01);
    addr = 7; run(10);
    #1 chk(rdata[0] == 1 && irq == 0, "R11", "flag without enable", {rdata[0], irq}, 2);

    cur_req = "R8";
    wr(0, 8'h00); wr(7, 8'h01);
    set_pl(24'd3);
    wr(0, 8'h03);
    addr = 4; run(30);
    cur_req = "R3";
    wr(0, 8'h02); run(4);

    cur_req = "R9";
    wr(7, 8'h01);
    set_pl(24'd4);
    wr(0, 8'h25);
    addr = 7; run(12);
    wr(7, 8'h01);
    addr = 6; run(20);
    #1 chk(rdata == 8'hFF, "R9", "wrapped count high byte", rdata, 8'hFF);
    chk(irq == 0, "R9", "no second interrupt", irq, 0);

    cur_req = "R5";
    wr(0, 8'h00);
    set_pl(24'd2);
    wr(0, 8'h31);
    addr = 4; run(200);

    cur_req = "R6";
    wr(0, 8'h00); wr(7, 8'h01);
    set_pl(24'd3);
    wr(0, 8'h29);
    addr = 4;
    for (int i = 0; i < 30; i++) begin
      ext_clk = 1'b1; run(1 + (i % 4));
      ext_clk = 1'b0; run(1 + (i % 3));
    end
    ext_clk = 1'b1; run(15); ext_clk = 1'b0; run(3);
    cur_req = "R5";
    wr(0, 8'h39);
    for (int i = 0; i < 100; i++) begin
      ext_clk = 1'b1; run(2); ext_clk = 1'b0; run(1 + (i % 2));
    end
    run(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule